// File: doc/BRIEF.md
# Nine-Bit Word Byte-Stream Packer

This block lets an ordinary byte-wide serial engine carry display words that are nine bits long. Each input beat is one byte tagged as either a command or data. The block adds the command/data flag as a ninth bit in front of the byte. It then concatenates eight such words MSB first into a 72-bit block and sends that block out as nine bytes. Both sides use valid/ready handshakes, so the block sits between a byte producer and the serialiser without either side needing to know the packing.

A command always travels alone in a block. Seven all-zero no-op words lead, and the command word, with its flag bit clear, sits in the final slot. Data bytes fill blocks in arrival order. When a run ends before a block is full, the rest of the block is filled with zero words. An optional mode exchanges the two bytes of each 16-bit pair before they are packed.

A command request must be exactly one byte long. Longer requests are discarded and reported on an error pulse. The ninth byte of every block carries a last flag, which lets the serialiser frame its transfers.

Top module: `ninebit_packer`

## Requirements
- R1: Word k of a block (k = 0..7) fills bits 71-9k down to 63-9k of a 72-bit block. Within the word, the flag bit comes first and the byte follows MSB first. Output byte j is bits 71-8j down to 64-8j. A data word has flag 1.
- R2: For a full data block, the first output byte is 1 followed by bits 7..1 of the first data byte. The ninth output byte equals the eighth data byte unchanged.
- R3: A command beat (in_is_data = 0, in_last = 1) produces its own block: eight 0x00 bytes, then the command byte.
- R4: A data run that ends (in_last = 1 on a data beat) after a number of bytes that is not a multiple of eight is completed with all-zero words. Its block is still nine bytes.
- R5: With swap16 = 1, data bytes are exchanged within each pair (byte 2i goes to word 2i+1 and byte 2i+1 goes to word 2i). A final byte at an even position of a run that has no partner stays at its own position.
- R6: A command request of more than one byte (command beats up to and including the one with in_last = 1) is dropped completely and produces no output. cmd_err is high for one cycle, one cycle after each dropped beat. A later one-byte command is handled normally.
- R7: A command that arrives while a data block is partly filled first flushes that block, zero-padded, and is then emitted as its own block.
- R8: out_last is high on the ninth byte of every block and on no other byte.
- R9: While out_valid is high and out_ready is low, out_byte and out_last hold. No byte is lost or repeated under backpressure.
- R10: During and just after reset, out_valid and cmd_err are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap16 | input | 1 | Exchange bytes within each 16-bit data pair; change only while idle |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_byte | input | 8 | Input byte |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Final byte of a data run or of a command request |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_byte | output | 8 | Packed output byte |
| out_last | output | 1 | Ninth byte of a block |
| cmd_err | output | 1 | One-cycle pulse for each dropped beat of an over-long command |

## Verification
Two events can coincide in one cycle. A command can close a partly filled data block while the emitter is still draining an earlier block, and the handoff of a waiting block can fall in the same cycle as the final byte of the previous block. The bench provokes both by sending data runs without an end mark followed immediately by a command, with random backpressure on out_ready. The scoreboard then judges the interleaving: it requires the padded data block, then the command block, in order, with no byte lost, duplicated or changed while stalled.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

   typedef enum logic {
      NBP_CMD  = 1'b0,
      NBP_DATA = 1'b1
   } nbp_kind_e;

   // bytes leaving the block for one packed group of words
   function automatic int unsigned nbp_block_bytes(input int unsigned wpb,
                                                   input int unsigned dw);
      return (wpb * (dw + 1)) / dw;
   endfunction

endpackage

// File: rtl/nbp_cmd_guard.sv
module nbp_cmd_guard
   import nbp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      beat_fire,
   input  nbp_kind_e beat_kind,
   input  logic      beat_last,
   output logic      drop,
   output logic      err
);

   logic open_q;   // inside a command request that already had a beat
   logic err_q;

   assign drop = (beat_kind == NBP_CMD) && (open_q || !beat_last);
   assign err  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= beat_fire && drop;
         if (beat_fire && (beat_kind == NBP_CMD))
            open_q <= !beat_last;
      end
   end

   // an over-long request must always be reported the cycle after a dropped beat
   assert_err_pulse_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (beat_fire && (beat_kind == NBP_CMD) && !beat_last) |=> err);

endmodule

// File: rtl/nbp_assembler.sv
module nbp_assembler
   import nbp_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned WPB     = 8,
   parameter bit          SWAP_EN = 1'b1,
   localparam int unsigned WW = DW + 1,
   localparam int unsigned BW = WPB * WW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          swap_mode,
   input  logic          beat_fire,
   input  logic [DW-1:0] beat_byte,
   input  nbp_kind_e     beat_kind,
   input  logic          beat_last,
   input  logic          drop,
   output logic          beat_ready,
   output logic          blk_valid,
   output logic [BW-1:0] blk_bits,
   input  logic          blk_take
);

   localparam int unsigned CW = $clog2(WPB + 1);
   localparam int unsigned IW = $clog2(WPB);

   logic [WW-1:0] slot_q [WPB];
   logic [CW-1:0] cnt_q;
   logic          full_q;
   logic          pend_q;
   logic [DW-1:0] pend_byte_q;
   logic [IW-1:0] wr_idx;
   logic [IW-1:0] base_idx;
   logic          wr_data;
   logic          wr_cmd;
   logic          run_closes;

   assign base_idx   = cnt_q[IW-1:0];
   assign wr_data    = beat_fire && (beat_kind == NBP_DATA);
   assign wr_cmd     = beat_fire && (beat_kind == NBP_CMD) && !drop;
   assign run_closes = beat_last || (cnt_q == CW'(WPB - 1));
   assign beat_ready = !full_q && !pend_q;
   assign blk_valid  = full_q;

   // slot choice: pair exchange variant or straight fill
   generate
      if (SWAP_EN) begin : g_swap
         logic lone_tail;
         assign lone_tail = beat_last && !base_idx[0];
         assign wr_idx = (swap_mode && !lone_tail) ? (base_idx ^ IW'(1)) : base_idx;
      end else begin : g_straight
         logic unused_swap;
         assign unused_swap = swap_mode;
         assign wr_idx = base_idx;
      end
   endgenerate

   // word k sits at the top end of the block, first on the wire
   generate
      for (genvar k = 0; k < WPB; k++) begin : g_flat
         assign blk_bits[BW-1-k*WW -: WW] = slot_q[k];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < WPB; k++) slot_q[k] <= '0;
         cnt_q       <= '0;
         full_q      <= 1'b0;
         pend_q      <= 1'b0;
         pend_byte_q <= '0;
      end else if (blk_take) begin
         for (int k = 0; k < WPB; k++) slot_q[k] <= '0;
         cnt_q  <= '0;
         full_q <= 1'b0;
         if (pend_q) begin
            slot_q[WPB-1] <= {1'b0, pend_byte_q};
            full_q        <= 1'b1;
            pend_q        <= 1'b0;
         end
      end else if (wr_data) begin
         slot_q[wr_idx] <= {1'b1, beat_byte};
         cnt_q          <= cnt_q + CW'(1);
         if (run_closes) full_q <= 1'b1;
      end else if (wr_cmd) begin
         full_q <= 1'b1;
         if (cnt_q == '0) begin
            slot_q[WPB-1] <= {1'b0, beat_byte};
         end else begin
            pend_q      <= 1'b1;
            pend_byte_q <= beat_byte;
         end
      end
   end

   assert_cnt_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(WPB));

   assert_take_full_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      blk_take |-> full_q);

   assert_drop_inert_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (beat_fire && drop) |=> ($stable(cnt_q) && $stable(full_q) && !pend_q));

endmodule

// File: rtl/nbp_emitter.sv
module nbp_emitter
   import nbp_pkg::*;
#(
   parameter int unsigned DW  = 8,
   parameter int unsigned WPB = 8,
   localparam int unsigned BW = WPB * (DW + 1),
   localparam int unsigned NB = nbp_block_bytes(WPB, DW),
   localparam int unsigned IW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blk_valid,
   input  logic [BW-1:0] blk_bits,
   output logic          blk_take,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_byte,
   output logic          out_last
);

   logic [BW-1:0] sh_q;
   logic [IW-1:0] idx_q;
   logic          busy_q;
   logic          fire;

   assign out_valid = busy_q;
   assign out_byte  = sh_q[BW-1 -: DW];
   assign out_last  = busy_q && (idx_q == IW'(NB - 1));
   assign fire      = out_valid && out_ready;
   assign blk_take  = blk_valid && (!busy_q || (fire && out_last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (blk_take) begin
         sh_q   <= blk_bits;
         idx_q  <= '0;
         busy_q <= 1'b1;
      end else if (fire) begin
         sh_q  <= sh_q << DW;
         idx_q <= idx_q + IW'(1);
         if (out_last) busy_q <= 1'b0;
      end
   end

   assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

   assert_last_valid_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

endmodule

// File: rtl/ninebit_packer.sv
module ninebit_packer
   import nbp_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned WPB     = 8,
   parameter bit          SWAP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          swap16,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_byte,
   input  logic          in_is_data,
   input  logic          in_last,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_byte,
   output logic          out_last,
   output logic          cmd_err
);

   localparam int unsigned BW = WPB * (DW + 1);

   generate
      if ((BW % DW) != 0) begin : g_bad_ratio
         $error("block of words must fill whole output bytes");
      end
      if (SWAP_EN && ((WPB % 2) != 0)) begin : g_bad_pairs
         $error("pair exchange needs an even word count per block");
      end
      if (WPB < 2) begin : g_bad_wpb
         $error("at least two words per block are required");
      end
   endgenerate

   nbp_kind_e     kind;
   logic          beat_fire;
   logic          drop;
   logic          asm_ready;
   logic          blk_valid;
   logic          blk_take;
   logic [BW-1:0] blk_bits;

   assign kind      = in_is_data ? NBP_DATA : NBP_CMD;
   assign in_ready  = asm_ready;
   assign beat_fire = in_valid && asm_ready;

   nbp_cmd_guard u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_fire (beat_fire),
      .beat_kind (kind),
      .beat_last (in_last),
      .drop      (drop),
      .err       (cmd_err)
   );

   nbp_assembler #(
      .DW      (DW),
      .WPB     (WPB),
      .SWAP_EN (SWAP_EN)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .swap_mode  (swap16),
      .beat_fire  (beat_fire),
      .beat_byte  (in_byte),
      .beat_kind  (kind),
      .beat_last  (in_last),
      .drop       (drop),
      .beat_ready (asm_ready),
      .blk_valid  (blk_valid),
      .blk_bits   (blk_bits),
      .blk_take   (blk_take)
   );

   nbp_emitter #(
      .DW  (DW),
      .WPB (WPB)
   ) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_valid (blk_valid),
      .blk_bits  (blk_bits),
      .blk_take  (blk_take),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_byte  (out_byte),
      .out_last  (out_last)
   );

endmodule

// File: tb/ninebit_packer_test.sv
`timescale 1ns/1ps
module ninebit_packer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       swap16 = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_byte = '0;
   logic       in_is_data = 1'b0;
   logic       in_last = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_byte;
   logic       out_last;
   logic       cmd_err;

   int checks = 0;
   int errors = 0;
   int err_seen = 0;
   int err_exp = 0;
   int cycles = 0;
   bit bp_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   logic [7:0] exp_b [$];
   logic       exp_l [$];
   string      exp_t [$];
   logic [8:0] mw [8];

   always #2.5 clk = ~clk;

   ninebit_packer uut (
      .clk(clk), .rst_n(rst_n), .swap16(swap16),
      .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
      .in_is_data(in_is_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
      .out_last(out_last), .cmd_err(cmd_err)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // expected model: pack the eight model words, flag bit first, MSB first
   task automatic exp_block(input string tag);
      logic [71:0] v;
      for (int k = 0; k < 8; k++) v[71-9*k -: 9] = mw[k];
      for (int j = 0; j < 9; j++) begin
         exp_b.push_back(v[71-8*j -: 8]);
         exp_l.push_back(j == 8);
         exp_t.push_back(tag);
      end
      for (int k = 0; k < 8; k++) mw[k] = '0;
   endtask

   task automatic drive_beat(input logic [7:0] b, input logic dat, input logic lst);
      in_byte = b; in_is_data = dat; in_last = lst; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // R3: seven zero words then the command word with flag 0
   task automatic send_cmd(input logic [7:0] c, input string tag);
      for (int k = 0; k < 8; k++) mw[k] = '0;
      mw[7] = {1'b0, c};
      exp_block(tag);
      drive_beat(c, 1'b0, 1'b1);
   endtask

   // R1 R2 R4 R5: data run, model follows the requirement text
   task automatic send_run(input int n, input bit with_last, input int seed,
                           input string tag);
      logic [7:0] d [$];
      for (int i = 0; i < n; i++) d.push_back(8'(seed * 7 + i * 29 + 3));
      for (int k = 0; k < 8; k++) mw[k] = '0;
      for (int i = 0; i < n; i++) begin
         int p;
         int s;
         p = i % 8;
         s = (swap16 && !(with_last && (i == n - 1) && (p % 2 == 0))) ? (p ^ 1) : p;
         mw[s] = {1'b1, d[i]};
         if (p == 7 || i == n - 1) exp_block(tag);
      end
      for (int i = 0; i < n; i++)
         drive_beat(d[i], 1'b1, with_last && (i == n - 1));
   endtask

   task automatic bad_cmd(input int len);
      for (int i = 0; i < len; i++) begin
         drive_beat(8'hB0 + 8'(i), 1'b0, i == len - 1);
         err_exp++;
      end
   endtask

   task automatic drain();
      int n = 0;
      while ((exp_b.size() != 0 || out_valid) && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
      chk(exp_b.size() == 0, "R9", "bytes missing", exp_b.size(), 0);
   endtask

   // downstream readiness changes just after the active edge
   always begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_en ? (lfsr[0] | lfsr[5]) : 1'b1;
   end

   // monitor / scoreboard, sampled at the falling edge
   logic       prev_stall = 1'b0;
   logic [7:0] prev_b = '0;
   logic       prev_l = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_err) err_seen++;
         if (prev_stall) begin
            chk(out_valid && out_byte == prev_b && out_last == prev_l, "R9",
                "stalled byte changed", {out_valid, out_last, out_byte},
                {1'b1, prev_l, prev_b});
         end
         prev_stall = out_valid && !out_ready;
         prev_b = out_byte;
         prev_l = out_last;
         if (out_valid && out_ready) begin
            if (exp_b.size() == 0) begin
               chk(1'b0, "R6", "unexpected byte", out_byte, 0);
            end else begin
               logic [7:0] eb;
               logic       el;
               string      et;
               eb = exp_b.pop_front();
               el = exp_l.pop_front();
               et = exp_t.pop_front();
               chk(out_byte == eb, et, "byte", out_byte, eb);
               chk(out_last == el, "R8", "last flag", out_last, el);
            end
         end
      end
   end

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 8; k++) mw[k] = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
      chk(cmd_err == 1'b0, "R10", "cmd_err in reset", cmd_err, 0);
      chk(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", "after reset",
          {out_valid, in_ready}, 2'b01);

      send_cmd(8'h2C, "R3");               // R3 single command block
      send_run(8, 1'b1, 1, "R2");          // R2 full block edges
      send_run(16, 1'b1, 2, "R1");         // R1 two back-to-back blocks
      send_run(3, 1'b1, 3, "R4");          // R4 tail padding
      send_run(13, 1'b1, 4, "R4");
      drain();
      send_run(5, 1'b0, 5, "R7");          // R7 open block closed by command
      send_cmd(8'h29, "R7");
      drain();

      swap16 = 1'b1;
      send_run(8, 1'b1, 6, "R5");          // R5 pair exchange
      send_run(5, 1'b1, 7, "R5");          // R5 lone final byte stays
      send_run(10, 1'b1, 8, "R5");
      drain();
      swap16 = 1'b0;

      bad_cmd(3);                          // R6 over-long command dropped
      bad_cmd(2);
      drain();
      chk(err_seen == err_exp, "R6", "error pulses", err_seen, err_exp);
      send_cmd(8'h11, "R6");               // R6 next short command still works
      drain();

      bp_en = 1'b1;                        // R9 backpressure with mixed traffic
      for (int r = 0; r < 6; r++) begin
         send_run(3 + r * 3, (r % 2) == 0, 20 + r, "R9");
         if ((r % 2) == 1) send_cmd(8'h30 + 8'(r), "R7");
         send_cmd(8'h40 + 8'(r), "R9");
      end
      drain();
      bp_en = 1'b0;
      chk(err_seen == err_exp, "R6", "no stray error pulses", err_seen, err_exp);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule